// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the state update a processor core makes when it takes an exception. The core posts a cause with `raise_i`, and that cause sits in a pending register. When the core pulses `take_i`, the block does two things on the same clock edge. It saves a return address in the exception PC register. It also copies the status register into the exception status register. The status register then switches to supervisor mode with the translation, interrupt and tick enables off.

One cycle after the take, the block gives the core a set of pulses:
- a PC load with the handler vector, which is the cause index times 256;
- a TLB flush request;
- a request to clear the core's delay-slot flag.

If the pending cause is missing or invalid, the block pulses an abort output instead and leaves every register as it was.

The saved return address depends on two things:
- Whether the faulting instruction sat in a branch delay slot.
- The class of the cause. Tick, external interrupt, syscall and floating-point causes let the instruction complete. Every other cause re-executes it.

The core can rewrite the status register with `sr_wr_i` whenever no take is in progress. All pins are plain control and status pins. The take is a single-cycle strobe that the block always accepts, so there is no back-pressure.

Top module: `exc_entry`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `epcr_o` and `esr_o` are 0 and `sr_o` is 16'h0001 (supervisor bit only). `pend_valid_o`, `pc_load_o`, `tlb_flush_o`, `dslot_clr_o` and `abort_o` are 0.
- R2: A valid take outside a delay slot with a completing cause (tick=5, external=8, syscall=12, FP=13) writes `npc_i` to `epcr_o`.
- R3: A valid take outside a delay slot with any other cause writes `pc_i` to `epcr_o`.
- R4: A valid take with `dslot_i`=1 and a completing cause writes `jmp_pc_i` to `epcr_o`.
- R5: A valid take with `dslot_i`=1 and a re-executing cause writes `pc_i` minus 4 to `epcr_o`.
- R6: On a valid take, `esr_o` takes the status value held before that edge.
- R7: On a valid take, the new status clears the tick-enable bit 1, the interrupt-enable bit 2, the data-translation bit 5 and the instruction-translation bit 6. It sets the supervisor bit 0, and it sets the delay-slot bit 13 when `dslot_i`=1. All other bits keep their values.
- R8: The cycle after a valid take, `pc_load_o` and `tlb_flush_o` pulse for one cycle and `pc_vec_o` equals the cause shifted left by 8. `dslot_clr_o` pulses only if `dslot_i` was 1.
- R9: A take with no pending cause, with cause 0, or with a cause of 15 or above pulses `abort_o` the next cycle. It gives no PC load and no flush, and it leaves `epcr_o`, `esr_o` and `sr_o` unchanged.
- R10: Without a take, `epcr_o` and `esr_o` hold their values and `sr_o` changes only through `sr_wr_i`. A take in the same cycle overrides the write.
- R11: `raise_i` sets the pending cause and `take_i` clears it to none. When both come in one cycle, the take uses the old cause and the new cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | Post a pending exception cause |
| raise_cause_i | input | 4 | Cause index to post |
| take_i | input | 1 | One-cycle strobe: take the pending exception |
| pc_i | input | 32 | PC of the current instruction |
| npc_i | input | 32 | PC of the next instruction |
| jmp_pc_i | input | 32 | Target of the pending jump |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_wr_i | input | 1 | Write the status register |
| sr_wdata_i | input | 16 | Status value to write |
| epcr_o | output | 32 | Exception PC register |
| esr_o | output | 16 | Exception status register |
| sr_o | output | 16 | Status register |
| pend_valid_o | output | 1 | A cause is pending |
| pend_cause_o | output | 4 | Pending cause index |
| pc_load_o | output | 1 | Pulse: load the PC with `pc_vec_o` |
| pc_vec_o | output | 32 | Handler vector address |
| tlb_flush_o | output | 1 | Pulse: flush the TLBs |
| dslot_clr_o | output | 1 | Pulse: clear the core's delay-slot flag |
| abort_o | output | 1 | Pulse: invalid cause taken |

## Verification
On every cycle, the assertions check the pulse shape after a take:
- A valid take gives a load and a flush together.
- An invalid take gives an abort with no load.
- `esr_o` tracks the prior status.
- The required status bits are set or cleared.
- The registers stay stable when no take or write occurs.

Only the bench scenarios can show that the right one of the four return addresses is chosen for each combination of delay slot and cause class. The same goes for the vector value, the boundary causes 0, 14 and 15, and the ordering of a raise and a take in the same cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [0:0] {
    CLS_REEXEC   = 1'b0,
    CLS_COMPLETE = 1'b1
  } exc_class_e;
endpackage

// File: rtl/exc_cause_check.sv
module exc_cause_check
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 4,
  parameter int NCAUSE  = 15,
  parameter int C_TICK  = 5,
  parameter int C_EXT   = 8,
  parameter int C_SYSC  = 12,
  parameter int C_FPE   = 13
) (
  input  logic               valid_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               ok_o,
  output exc_class_e         cls_o
);
  localparam logic [CAUSE_W:0]   LIMIT = NCAUSE[CAUSE_W:0];
  localparam logic [CAUSE_W-1:0] K_TICK = C_TICK[CAUSE_W-1:0];
  localparam logic [CAUSE_W-1:0] K_EXT  = C_EXT[CAUSE_W-1:0];
  localparam logic [CAUSE_W-1:0] K_SYSC = C_SYSC[CAUSE_W-1:0];
  localparam logic [CAUSE_W-1:0] K_FPE  = C_FPE[CAUSE_W-1:0];

  logic nonzero, in_range, completes;

  always_comb begin
    nonzero   = |cause_i;
    in_range  = {1'b0, cause_i} < LIMIT;
    completes = (cause_i == K_TICK) || (cause_i == K_EXT) ||
                (cause_i == K_SYSC) || (cause_i == K_FPE);
    ok_o      = valid_i && nonzero && in_range;
    cls_o     = completes ? CLS_COMPLETE : CLS_REEXEC;
  end
endmodule

// File: rtl/exc_epc_select.sv
module exc_epc_select
  import exc_entry_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INSN_B = 4
) (
  input  exc_class_e        cls_i,
  input  logic              dslot_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   npc_i,
  input  logic [PC_W-1:0]   jmp_pc_i,
  output logic [PC_W-1:0]   epc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_B);

  always_comb begin
    unique case ({dslot_i, cls_i})
      {1'b1, CLS_COMPLETE}: epc_o = jmp_pc_i;
      {1'b1, CLS_REEXEC}:   epc_o = pc_i - STEP;
      {1'b0, CLS_COMPLETE}: epc_o = npc_i;
      default:              epc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update #(
  parameter int SR_W    = 16,
  parameter int SM_BIT  = 0,
  parameter int TEE_BIT = 1,
  parameter int IEE_BIT = 2,
  parameter int DME_BIT = 5,
  parameter int IME_BIT = 6,
  parameter int DSX_BIT = 13
) (
  input  logic [SR_W-1:0] sr_i,
  input  logic            dslot_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] clr_mask, set_mask, dsx_mask;

  for (genvar i = 0; i < SR_W; i++) begin : g_bit
    assign clr_mask[i] = (i == TEE_BIT) || (i == IEE_BIT) ||
                         (i == DME_BIT) || (i == IME_BIT);
    assign set_mask[i] = (i == SM_BIT);
    assign dsx_mask[i] = (i == DSX_BIT);
  end

  always_comb begin
    sr_o = (sr_i & ~clr_mask) | set_mask;
    if (dslot_i) sr_o = sr_o | dsx_mask;
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 4,
  parameter int SR_W      = 16,
  parameter int NCAUSE    = 15,
  parameter int VEC_SHIFT = 8,
  parameter int C_TICK    = 5,
  parameter int C_EXT     = 8,
  parameter int C_SYSC    = 12,
  parameter int C_FPE     = 13,
  parameter int SM_BIT    = 0,
  parameter int TEE_BIT   = 1,
  parameter int IEE_BIT   = 2,
  parameter int DME_BIT   = 5,
  parameter int IME_BIT   = 6,
  parameter int DSX_BIT   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_i,
  input  logic [CAUSE_W-1:0] raise_cause_i,
  input  logic               take_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    npc_i,
  input  logic [PC_W-1:0]    jmp_pc_i,
  input  logic               dslot_i,
  input  logic               sr_wr_i,
  input  logic [SR_W-1:0]    sr_wdata_i,
  output logic [PC_W-1:0]    epcr_o,
  output logic [SR_W-1:0]    esr_o,
  output logic [SR_W-1:0]    sr_o,
  output logic               pend_valid_o,
  output logic [CAUSE_W-1:0] pend_cause_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_vec_o,
  output logic               tlb_flush_o,
  output logic               dslot_clr_o,
  output logic               abort_o
);
  localparam logic [SR_W-1:0] SR_RST = SR_W'(1) << SM_BIT;

  logic               pend_v_q;
  logic [CAUSE_W-1:0] pend_c_q;
  logic [PC_W-1:0]    epcr_q, vec_q;
  logic [SR_W-1:0]    esr_q, sr_q;
  logic               load_q, flush_q, dsclr_q, abort_q;

  logic            cause_ok;
  exc_class_e      cause_cls;
  logic [PC_W-1:0] epc_sel;
  logic [SR_W-1:0] sr_next;
  logic            take_ok, take_bad;

  exc_cause_check #(
    .CAUSE_W(CAUSE_W), .NCAUSE(NCAUSE), .C_TICK(C_TICK),
    .C_EXT(C_EXT), .C_SYSC(C_SYSC), .C_FPE(C_FPE)
  ) u_check (
    .valid_i(pend_v_q), .cause_i(pend_c_q),
    .ok_o(cause_ok), .cls_o(cause_cls)
  );

  exc_epc_select #(.PC_W(PC_W), .INSN_B(4)) u_epc (
    .cls_i(cause_cls), .dslot_i(dslot_i), .pc_i(pc_i),
    .npc_i(npc_i), .jmp_pc_i(jmp_pc_i), .epc_o(epc_sel)
  );

  exc_sr_update #(
    .SR_W(SR_W), .SM_BIT(SM_BIT), .TEE_BIT(TEE_BIT), .IEE_BIT(IEE_BIT),
    .DME_BIT(DME_BIT), .IME_BIT(IME_BIT), .DSX_BIT(DSX_BIT)
  ) u_sr (
    .sr_i(sr_q), .dslot_i(dslot_i), .sr_o(sr_next)
  );

  assign take_ok  = take_i && cause_ok;
  assign take_bad = take_i && !cause_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_c_q <= '0;
      epcr_q   <= '0;
      esr_q    <= '0;
      sr_q     <= SR_RST;
      vec_q    <= '0;
      load_q   <= 1'b0;
      flush_q  <= 1'b0;
      dsclr_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      load_q  <= take_ok;
      flush_q <= take_ok;
      dsclr_q <= take_ok && dslot_i;
      abort_q <= take_bad;
      if (take_ok) begin
        epcr_q <= epc_sel;
        esr_q  <= sr_q;
        sr_q   <= sr_next;
        vec_q  <= PC_W'(pend_c_q) << VEC_SHIFT;
      end else if (!take_i && sr_wr_i) begin
        sr_q <= sr_wdata_i;
      end
      if (raise_i) begin
        pend_v_q <= 1'b1;
        pend_c_q <= raise_cause_i;
      end else if (take_i) begin
        pend_v_q <= 1'b0;
        pend_c_q <= '0;
      end
    end
  end

  assign epcr_o       = epcr_q;
  assign esr_o        = esr_q;
  assign sr_o         = sr_q;
  assign pend_valid_o = pend_v_q;
  assign pend_cause_o = pend_c_q;
  assign pc_load_o    = load_q;
  assign pc_vec_o     = vec_q;
  assign tlb_flush_o  = flush_q;
  assign dslot_clr_o  = dsclr_q;
  assign abort_o      = abort_q;

  a_r8_load_flush: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (pc_load_o && tlb_flush_o && !abort_o));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !pc_load_o || $past(take_i));

  a_r9_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> (abort_o && !pc_load_o && !tlb_flush_o &&
                  $stable(epcr_o) && $stable(esr_o) && $stable(sr_o)));

  a_r6_esr_copy: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> esr_o == $past(sr_o));

  a_r7_sr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (sr_o[SM_BIT] && !sr_o[TEE_BIT] && !sr_o[IEE_BIT] &&
                 !sr_o[DME_BIT] && !sr_o[IME_BIT] &&
                 (sr_o[DSX_BIT] == ($past(sr_o[DSX_BIT]) || $past(dslot_i)))));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !sr_wr_i) |=> ($stable(epcr_o) && $stable(esr_o) &&
                               $stable(sr_o) && !pc_load_o && !abort_o));

  a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !raise_i) |=> !pend_valid_o);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load_o, abort_o}));
endmodule

// File: tb/exc_entry_tb.sv
`timescale 1ns/1ps
module exc_entry_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_i = 1'b0;
  logic [3:0]  raise_cause_i = '0;
  logic        take_i = 1'b0;
  logic [31:0] pc_i = '0, npc_i = '0, jmp_pc_i = '0;
  logic        dslot_i = 1'b0;
  logic        sr_wr_i = 1'b0;
  logic [15:0] sr_wdata_i = '0;
  logic [31:0] epcr_o, pc_vec_o;
  logic [15:0] esr_o, sr_o;
  logic        pend_valid_o;
  logic [3:0]  pend_cause_o;
  logic        pc_load_o, tlb_flush_o, dslot_clr_o, abort_o;

  always #4 clk = ~clk;

  exc_entry u_dut (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .raise_cause_i(raise_cause_i),
    .take_i(take_i), .pc_i(pc_i), .npc_i(npc_i), .jmp_pc_i(jmp_pc_i),
    .dslot_i(dslot_i), .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
    .epcr_o(epcr_o), .esr_o(esr_o), .sr_o(sr_o), .pend_valid_o(pend_valid_o),
    .pend_cause_o(pend_cause_o), .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o),
    .tlb_flush_o(tlb_flush_o), .dslot_clr_o(dslot_clr_o), .abort_o(abort_o)
  );

  typedef struct {
    logic [31:0] epcr;
    logic [15:0] esr;
    logic [15:0] sr;
    logic [31:0] vec;
    logic        ds;
    logic        ab;
    string       etag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nerr = 0;
  logic [31:0] epcr_m = '0, vec_m = '0;
  logic [15:0] esr_m = '0, sr_m = 16'h0001;
  logic [3:0]  pend_m = '0;
  logic        pend_v_m = 1'b0;

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic bit completes(input logic [3:0] c);
    return (c == 4'd5) || (c == 4'd8) || (c == 4'd12) || (c == 4'd13);
  endfunction

  task automatic raise(input logic [3:0] c);
    @(negedge clk);
    raise_i = 1'b1; raise_cause_i = c;
    @(negedge clk);
    raise_i = 1'b0;
    pend_v_m = 1'b1; pend_m = c;
    chk(pend_valid_o == 1'b1 && pend_cause_o == c, "R11 raise", {27'd0, pend_valid_o, pend_cause_o}, {27'd0, 1'b1, c});
  endtask

  // Takes the currently pending cause; raise_new>0 posts a new cause in the same cycle.
  task automatic take(input logic [31:0] pc, input logic [31:0] npc, input logic [31:0] jmp,
                      input logic ds, input logic [4:0] raise_new);
    exp_t e;
    bit valid, cmp;
    valid = pend_v_m && pend_m != 0 && pend_m < 4'd15;
    cmp = completes(pend_m);
    if (!(raise_i === 1'b0)) ;
    take_i = 1'b1; pc_i = pc; npc_i = npc; jmp_pc_i = jmp; dslot_i = ds;
    if (raise_new != 0) begin raise_i = 1'b1; raise_cause_i = raise_new[3:0]; end
    if (valid) begin
      if (ds) begin e.epcr = cmp ? jmp : pc - 32'd4; e.etag = cmp ? "R4" : "R5"; end
      else    begin e.epcr = cmp ? npc : pc;         e.etag = cmp ? "R2" : "R3"; end
      e.esr = sr_m;
      sr_m = (sr_m & ~16'h0066) | 16'h0001 | (ds ? 16'h2000 : 16'h0000);
      e.sr = sr_m;
      e.vec = {24'd0, pend_m} << 8;
      e.ds = ds; e.ab = 1'b0;
      epcr_m = e.epcr; esr_m = e.esr; vec_m = e.vec;
    end else begin
      e.epcr = epcr_m; e.esr = esr_m; e.sr = sr_m; e.vec = vec_m;
      e.ds = 1'b0; e.ab = 1'b1; e.etag = "R9";
    end
    q.push_back(e);
    @(negedge clk);
    take_i = 1'b0; raise_i = 1'b0; dslot_i = 1'b0;
    if (raise_new != 0) begin pend_v_m = 1'b1; pend_m = raise_new[3:0]; end
    else begin pend_v_m = 1'b0; pend_m = '0; end
    chk(pend_valid_o == pend_v_m && pend_cause_o == pend_m, "R11 pending after take",
        {27'd0, pend_valid_o, pend_cause_o}, {27'd0, pend_v_m, pend_m});
  endtask

  // Monitor: pops an expected item for every load or abort pulse.
  always @(negedge clk) begin
    if (rst_n && (pc_load_o || abort_o)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected pulse", {30'd0, pc_load_o, abort_o}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(epcr_o == e.epcr, {e.etag, " epcr"}, epcr_o, e.epcr);
        chk(esr_o == e.esr, e.ab ? "R9 esr hold" : "R6 esr", {16'd0, esr_o}, {16'd0, e.esr});
        chk(sr_o == e.sr, e.ab ? "R9 sr hold" : "R7 sr", {16'd0, sr_o}, {16'd0, e.sr});
        chk(abort_o == e.ab && pc_load_o == !e.ab, "R9 abort/load",
            {30'd0, abort_o, pc_load_o}, {30'd0, e.ab, !e.ab});
        chk(tlb_flush_o == !e.ab, "R8 flush", {31'd0, tlb_flush_o}, {31'd0, !e.ab});
        chk(dslot_clr_o == e.ds, "R8 dslot clear", {31'd0, dslot_clr_o}, {31'd0, e.ds});
        if (!e.ab) chk(pc_vec_o == e.vec, "R8 vector", pc_vec_o, e.vec);
      end
    end
  end

  task automatic sr_write(input logic [15:0] d);
    @(negedge clk);
    sr_wr_i = 1'b1; sr_wdata_i = d;
    @(negedge clk);
    sr_wr_i = 1'b0;
    sr_m = d;
    chk(sr_o == d, "R10 sr write", {16'd0, sr_o}, {16'd0, d});
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(epcr_o == 0 && esr_o == 0, "R1 reset epcr/esr", epcr_o, 32'd0);
    chk(sr_o == 16'h0001, "R1 reset sr", {16'd0, sr_o}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pend_valid_o, pc_load_o, tlb_flush_o, dslot_clr_o, abort_o} == 0, "R1 reset pulses",
        {27'd0, pend_valid_o, pc_load_o, tlb_flush_o, dslot_clr_o, abort_o}, 32'd0);
    chk(sr_o == 16'h0001 && epcr_o == 0, "R1 after reset", {16'd0, sr_o}, 32'h1);

    sr_write(16'hFFFE);
    raise(4'd8);  take(32'h1000, 32'h1004, 32'h2000, 1'b0, 5'd0);  // R2
    sr_write(16'h0066);
    raise(4'd2);  take(32'h1100, 32'h1104, 32'h2100, 1'b0, 5'd0);  // R3
    sr_write(16'h5A5A);
    raise(4'd12); take(32'h1200, 32'h1204, 32'h3000, 1'b1, 5'd0);  // R4
    raise(4'd9);  take(32'h1300, 32'h1304, 32'h3100, 1'b1, 5'd0);  // R5
    raise(4'd5);  take(32'h1400, 32'h1404, 32'h3200, 1'b1, 5'd0);  // R4 tick
    raise(4'd13); take(32'h1500, 32'h1504, 32'h3300, 1'b0, 5'd0);  // R2 fpe
    raise(4'd14); take(32'h0000, 32'h0004, 32'h3400, 1'b1, 5'd0);  // R5 boundary, wraps
    raise(4'd1);  take(32'h1600, 32'h1604, 32'h3500, 1'b0, 5'd0);  // R3 lowest cause

    take(32'h1700, 32'h1704, 32'h3600, 1'b0, 5'd0);                 // R9 nothing pending
    raise(4'd0);  take(32'h1800, 32'h1804, 32'h3700, 1'b1, 5'd0);  // R9 cause zero
    raise(4'd15); take(32'h1900, 32'h1904, 32'h3800, 1'b0, 5'd0);  // R9 cause 15

    raise(4'd8);  take(32'h2000, 32'h2004, 32'h4000, 1'b0, 5'd3);  // R11 same-cycle raise
    take(32'h2100, 32'h2104, 32'h4100, 1'b0, 5'd0);                 // R3 takes cause 3

    // R10: take overrides a same-cycle status write
    raise(4'd4);
    sr_wr_i = 1'b1; sr_wdata_i = 16'h00FF;
    take(32'h2200, 32'h2204, 32'h4200, 1'b0, 5'd0);
    sr_wr_i = 1'b0;
    @(negedge clk);
    chk(sr_o == sr_m, "R10 take over write", {16'd0, sr_o}, {16'd0, sr_m});

    // R10: idle cycles leave everything alone
    repeat (6) @(negedge clk);
    chk(epcr_o == epcr_m && esr_o == esr_m && sr_o == sr_m, "R10 idle hold", epcr_o, epcr_m);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R8 all results seen", q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule